// File: doc/BRIEF.md
# Flash Program/Erase Status Generator

This block forms the status byte that a NOR flash returns when the host reads it while an internal program or erase operation is running. A controller supplies the current operating mode, and the host side supplies a read strobe. The block also receives a flag saying whether the read address falls inside a block being erased, a chip-erase flag, the data bit being written, a failure pulse, an erase-window-expired flag and a clear request from a read/reset instruction. From these it builds the byte the host sees.

Host software polls the byte in two ways. It compares bit 7 against the data it wrote, or it watches bits 6 and 2 for changes between reads. Bit 5 reports a failure and bit 3 shows whether more blocks can still be added to an erase. Bits 0, 1 and 4 are always driven low. The toggle flops advance once for each completed read access, detected on the rising edge of the strobe.

The mode input uses these codes:

- 0: idle
- 1: program
- 2: erase
- 3: erase suspended
- 4: program during suspend
- 5 to 7: treated as idle

Top module: `flash_status_gen`

## Requirements
- R1: After reset, with mode 0 and all other inputs low, the status byte is 8'h84.
- R2: In mode 1 or 4, bit 7 is the complement of `prog_bit_i` and bit 2 reads 1. Bit 3 reads 0 in mode 1 and 1 in mode 4.
- R3: In mode 2, bit 7 reads 0. In idle, bit 7 shows the last written bit if the last operation was a program, and 1 if it was an erase (or nothing since reset).
- R4: Bit 6 inverts once per rising edge of `rd_strobe_i` in modes 1, 2 and 4. It holds its value in idle and in mode 3.
- R5: Bit 2 inverts once per read rising edge in modes 2 and 3 when `in_erase_blk_i` or `chip_erase_i` is high. Otherwise it reads 1.
- R6: Bit 5 is set by `fail_i`, stays set across mode changes, and is cleared only by `clear_i`. If both are high in the same cycle, the set wins.
- R7: In mode 2, bit 3 equals `win_expired_i`. In mode 3, bit 3 reads 1.
- R8: In mode 3, a read of an erased block returns bit 7 = 1. A read of any other block returns `array_i` unchanged.
- R9: Bits 4, 1 and 0 are always 0, except in the mode 3 array pass-through.
- R10: A read strobe held high for several cycles counts as a single read.
- R11: Mode codes 5 to 7 behave exactly like idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| mode_i | input | 3 | Controller mode code |
| rd_strobe_i | input | 1 | Read access strobe, high for the duration of a read |
| in_erase_blk_i | input | 1 | Read address lies in a block being erased |
| chip_erase_i | input | 1 | The erase in progress covers the whole array |
| prog_bit_i | input | 1 | Bit 7 of the data being programmed |
| fail_i | input | 1 | Program or erase failure pulse |
| clear_i | input | 1 | Read/reset instruction accepted |
| win_expired_i | input | 1 | Multi-block erase window has closed |
| array_i | input | 8 | Array data for reads outside the suspended block |
| status_o | output | 8 | Status byte |

## Verification
The bench targets several corner cases, each paired with the fault it would expose:

- **Read held over several cycles.** A design that counted strobe level instead of edges would advance bit 6 several times.
- **Bit 2 outside the erased block.** A design that ignored the block address would toggle bit 2 there instead of holding it at 1.
- **Chip erase.** A design that skipped the chip-erase override would freeze bit 2 for those reads.
- **Idle after each kind of operation.** This separates a polling bit that remembers the last programmed value from one that is simply forced high.
- **Error flag.** A set and a clear arrive together, and a mode change follows a failure. A wrong priority or a mode-gated flag would then lose the failure.

// File: rtl/flash_status_gen.sv
module flash_status_gen #(
  parameter int MODE_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [MODE_W-1:0] mode_i,
  input  logic              rd_strobe_i,
  input  logic              in_erase_blk_i,
  input  logic              chip_erase_i,
  input  logic              prog_bit_i,
  input  logic              fail_i,
  input  logic              clear_i,
  input  logic              win_expired_i,
  input  logic [7:0]        array_i,
  output logic [7:0]        status_o
);
  localparam logic [MODE_W-1:0] M_PROG  = MODE_W'(1);
  localparam logic [MODE_W-1:0] M_ERASE = MODE_W'(2);
  localparam logic [MODE_W-1:0] M_SUSP  = MODE_W'(3);
  localparam logic [MODE_W-1:0] M_SPROG = MODE_W'(4);

  logic rd_q, tog6_q, tog2_q, err_q, last_prog_q, last_bit_q;

  wire is_prog   = (mode_i == M_PROG) || (mode_i == M_SPROG);
  wire is_erase  = (mode_i == M_ERASE);
  wire is_susp   = (mode_i == M_SUSP);
  wire erase_hit = in_erase_blk_i | chip_erase_i;
  wire rd_rise   = rd_strobe_i & ~rd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q        <= 1'b0;
      tog6_q      <= 1'b0;
      tog2_q      <= 1'b0;
      err_q       <= 1'b0;
      last_prog_q <= 1'b0;
      last_bit_q  <= 1'b0;
    end else begin
      rd_q <= rd_strobe_i;
      if (rd_rise && (is_prog || is_erase))
        tog6_q <= ~tog6_q;
      if (rd_rise && (is_erase || is_susp) && erase_hit)
        tog2_q <= ~tog2_q;
      if (fail_i)
        err_q <= 1'b1;
      else if (clear_i)
        err_q <= 1'b0;
      if (is_prog) begin
        last_prog_q <= 1'b1;
        last_bit_q  <= prog_bit_i;
      end else if (is_erase) begin
        last_prog_q <= 1'b0;
      end
    end
  end

  always_comb begin
    status_o    = 8'h00;
    status_o[6] = tog6_q;
    status_o[5] = err_q;
    status_o[2] = 1'b1;
    if (is_prog) begin
      status_o[7] = ~prog_bit_i;
      status_o[3] = (mode_i == M_SPROG);
    end else if (is_erase) begin
      status_o[7] = 1'b0;
      status_o[3] = win_expired_i;
      if (erase_hit)
        status_o[2] = tog2_q;
    end else if (is_susp) begin
      if (erase_hit) begin
        status_o[7] = 1'b1;
        status_o[3] = 1'b1;
        status_o[2] = tog2_q;
      end else begin
        status_o = array_i;
      end
    end else begin
      status_o[7] = last_prog_q ? last_bit_q : 1'b1;
    end
  end
endmodule

module flash_status_gen_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [2:0] mode_i,
  input logic       rd_strobe_i,
  input logic       in_erase_blk_i,
  input logic       chip_erase_i,
  input logic       prog_bit_i,
  input logic       fail_i,
  input logic       clear_i,
  input logic [7:0] array_i,
  input logic [7:0] status_o,
  input logic       rd_q,
  input logic       tog6_q,
  input logic       err_q
);
  wire passthru = (mode_i == 3'd3) && !in_erase_blk_i && !chip_erase_i;

  a_r9_reserved_low: assert property (@(posedge clk) disable iff (!rst_n)
    !passthru |-> (status_o[4] == 1'b0 && status_o[1:0] == 2'b00));

  a_r6_err_sets: assert property (@(posedge clk) disable iff (!rst_n)
    fail_i |=> status_o[5] || passthru);

  a_r6_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (err_q && !clear_i) |=> err_q);

  a_r4_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == 3'd0 || mode_i == 3'd3) |=> $stable(tog6_q));

  a_r10_edge_only: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_strobe_i && !rd_q) |=> $stable(tog6_q));

  a_r2_poll_inverted: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == 3'd1) |-> (status_o[7] == !prog_bit_i));

  a_r8_array_pass: assert property (@(posedge clk) disable iff (!rst_n)
    passthru |-> (status_o == array_i));
endmodule

bind flash_status_gen flash_status_gen_chk i_chk (
  .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .rd_strobe_i(rd_strobe_i),
  .in_erase_blk_i(in_erase_blk_i), .chip_erase_i(chip_erase_i),
  .prog_bit_i(prog_bit_i), .fail_i(fail_i), .clear_i(clear_i),
  .array_i(array_i), .status_o(status_o), .rd_q(rd_q), .tog6_q(tog6_q),
  .err_q(err_q)
);

// File: tb/test_flash_status_gen.sv
module test_flash_status_gen;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 13;
  // {mode[24:22], inblk, chip, pbit, win, flip6, flip2, mask[15:8], val[7:0]}
  localparam logic [24:0] VEC [NV] = '{
    {3'd1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 8'hBF, 8'h04},
    {3'd1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 8'hBF, 8'h84},
    {3'd2, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 8'hBB, 8'h08},
    {3'd2, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 8'hBF, 8'h0C},
    {3'd2, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 8'hBB, 8'h00},
    {3'd3, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 8'hBB, 8'h88},
    {3'd3, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 8'hFF, 8'h5A},
    {3'd4, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 8'hBF, 8'h8C},
    {3'd0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 8'hBF, 8'h04},
    {3'd2, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 8'hBB, 8'h08},
    {3'd0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 8'hBF, 8'h84},
    {3'd7, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 8'hBF, 8'h84},
    {3'd5, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 8'hBF, 8'h84}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic [2:0] mode = '0;
  logic rd = 0, inblk = 0, chip = 0, pbit = 0, fail = 0, clr = 0, win = 0;
  logic [7:0] arr = 8'h5A;
  logic [7:0] status;
  int tests = 0, fails = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_status_gen i_flash_status_gen (
    .clk(clk), .rst_n(rst_n), .mode_i(mode), .rd_strobe_i(rd),
    .in_erase_blk_i(inblk), .chip_erase_i(chip), .prog_bit_i(pbit),
    .fail_i(fail), .clear_i(clr), .win_expired_i(win), .array_i(arr),
    .status_o(status)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic string tag(input logic [2:0] m);
    case (m)
      3'd1, 3'd4: return "R2";
      3'd2:       return "R3/R7";
      3'd3:       return "R8";
      3'd0:       return "R3";
      default:    return "R11";
    endcase
  endfunction

  task automatic read_pulse(input int hold);
    @(negedge clk) rd = 1'b1;
    for (int k = 0; k < hold; k++) @(negedge clk);
    rd = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    if (!done) begin
      fails++;
      tests++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] s0;
    repeat (3) @(negedge clk);
    check("R1 reset value", status, 8'h84);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release", status, 8'h84);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      mode  = VEC[i][24:22];
      inblk = VEC[i][21];
      chip  = VEC[i][20];
      pbit  = VEC[i][19];
      win   = VEC[i][18];
      @(negedge clk);
      s0 = status;
      read_pulse(1);
      check(tag(VEC[i][24:22]), status & VEC[i][15:8], VEC[i][7:0]);
      check("R4 bit6 flip", {7'd0, status[6] ^ s0[6]}, {7'd0, VEC[i][17]});
      check("R5 bit2 flip", {7'd0, status[2] ^ s0[2]}, {7'd0, VEC[i][16]});
      if (!(VEC[i][24:22] == 3'd3 && !VEC[i][21]))
        check("R9 reserved", status & 8'h13, 8'h00);
    end

    // R10: strobe held five cycles flips bit 6 once
    @(negedge clk) begin mode = 3'd1; inblk = 0; chip = 0; end
    @(negedge clk) s0 = status;
    read_pulse(5);
    check("R10 long read", {7'd0, status[6]}, {7'd0, ~s0[6]});

    // R6: error flag
    @(negedge clk) fail = 1'b1;
    @(negedge clk) fail = 1'b0;
    check("R6 set in program", {7'd0, status[5]}, 8'd1);
    mode = 3'd0;
    @(negedge clk);
    check("R6 survives mode change", {7'd0, status[5]}, 8'd1);
    clr = 1'b1;
    @(negedge clk) clr = 1'b0;
    check("R6 cleared", {7'd0, status[5]}, 8'd0);
    fail = 1'b1; clr = 1'b1;
    @(negedge clk) begin fail = 1'b0; clr = 1'b0; end
    check("R6 set wins", {7'd0, status[5]}, 8'd1);
    clr = 1'b1;
    @(negedge clk) clr = 1'b0;
    check("R6 cleared again", {7'd0, status[5]}, 8'd0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule